// File: doc/BRIEF.md
# Label-Aware Store Ordering Unit

This unit sits between one core's load/store port and a single memory port. Every access comes with a consistency label: non-competing, loop-competing or non-loop-competing. Stores go into a small buffer and leave for memory strictly oldest first. The labels decide whether a load may run ahead of stores that are still buffered.

A load goes ahead of older buffered stores unless the load is non-loop and at least one buffered store is also non-loop. Any other load is accepted at once. If a buffered store holds its address, the load takes the data of the youngest such store. Otherwise it reads memory ahead of the stores that are still waiting.

An atomic read-modify-write waits until the buffer is empty. It then reads the old value and writes the new one back with no other memory request between the two. A fence also waits until the buffer is empty.

The core request channel and the memory request channel are valid/ready. The core raises `req_valid` and holds the command until `req_ready` is high at a rising edge. The unit holds a memory request unchanged until `mem_req_ready` is high at a rising edge. A read result stays on `rsp_valid`/`rsp_rdata` until `rsp_ready` accepts it. Memory acknowledges each read or write with a one-cycle `mem_rsp_valid` pulse and takes only one transaction at a time.

Top module: `lbl_order_unit`

## Requirements
- R1: After reset, `rsp_valid` and `mem_req_valid` are low, and the unit is ready for a load or store on an empty buffer.
- R2: Up to DEPTH (8) stores are buffered. `req_ready` is low for a store while the buffer is full. Stores reach the memory port in acceptance order with their address, data and label, one transaction at a time, and an entry retires on its acknowledge.
- R3: A load labelled non-loop is held off (`req_ready` low) while any non-loop store is buffered or in flight. Its memory read never appears before those stores have been issued.
- R4: A load labelled loop or non-competing is accepted even with stores buffered, and its memory read may reach the port before older stores.
- R5: A load whose address matches buffered stores returns the youngest matching data without a memory read.
- R6: A read-modify-write (op 2) is accepted only on an empty buffer. It reads, then writes `req_wdata` to the same address with no request in between, and returns the old value.
- R7: A fence (op 3) is accepted only once every older store has gone to memory, and it produces no response.
- R8: A read result stays valid and unchanged until `rsp_ready`, and no new command is accepted meanwhile.
- R9: A memory request stays valid with stable address, data and direction until `mem_req_ready`.
- R10: Encodings: `req_op` 0 load, 1 store, 2 read-modify-write, 3 fence. Label 0 non-competing, 1 loop, 2 non-loop. Label 3 is treated as non-loop, so ordering stays safe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core command valid |
| req_ready | output | 1 | Command accepted at this edge |
| req_op | input | 2 | Command kind (R10) |
| req_label | input | 2 | Consistency label (R10) |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store or swap data |
| rsp_valid | output | 1 | Read result valid |
| rsp_ready | input | 1 | Core takes the result |
| rsp_rdata | output | DW | Read result |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_label | output | 2 | Label of the access |
| mem_req_addr | output | AW | Memory address |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Acknowledge pulse, carries read data |
| mem_rsp_rdata | input | DW | Read data |

## Verification
A wrong pointer or count in the buffer shows at the memory port with the next drained store. Its address, data or label stops matching the program order of accepted stores, or the full stall comes one entry early or late. A missing non-loop mark shows in the first non-loop load behind a non-loop store: the load is either accepted at once or its read reaches memory ahead of that store. Wrong forwarding shows on the very next load to a buffered address, either as stale data or as a memory read where none should happen.

// File: rtl/lbl_pkg.sv
package lbl_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_RMW   = 2'd2,
    OP_FENCE = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_RSP
  } state_e;

  // Labels 2 and 3 both count as non-loop (conservative for code 3).
  function automatic logic is_nonloop(input logic [1:0] lbl);
    return lbl[1];
  endfunction

endpackage

// File: rtl/sb_queue.sv
// Circular store buffer; DEPTH must be a power of two, at least 2.
module sb_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic [AW-1:0]        push_addr,
  input  logic [DW-1:0]        push_data,
  input  logic [1:0]           push_lbl,
  input  logic                 pop,
  output logic [AW-1:0]        ent_addr [DEPTH],
  output logic [DW-1:0]        ent_data [DEPTH],
  output logic [1:0]           ent_lbl  [DEPTH],
  output logic [DEPTH-1:0]     ent_vld,
  output logic [$clog2(DEPTH)-1:0] rd_ptr,
  output logic                 empty,
  output logic                 full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [1:0]    lbl_q  [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PW'(1);
      if (pop)  rd_ptr <= rd_ptr + PW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr] <= push_addr;
      data_q[wr_ptr] <= push_data;
      lbl_q[wr_ptr]  <= push_lbl;
    end
  end

  assign ent_addr = addr_q;
  assign ent_data = data_q;
  assign ent_lbl  = lbl_q;
  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));

  for (genvar i = 0; i < DEPTH; i++) begin : g_vld
    logic [PW-1:0] age;
    assign age        = PW'(i) - rd_ptr;
    assign ent_vld[i] = ({1'b0, age} < cnt);
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/sb_lookup.sv
// Youngest-match forwarding and non-loop presence over the buffer.
module sb_lookup #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic [AW-1:0]            ent_addr [DEPTH],
  input  logic [DW-1:0]            ent_data [DEPTH],
  input  logic [1:0]               ent_lbl  [DEPTH],
  input  logic [DEPTH-1:0]         ent_vld,
  input  logic [$clog2(DEPTH)-1:0] rd_ptr,
  input  logic [AW-1:0]            look_addr,
  output logic                     hit,
  output logic [DW-1:0]            hit_data,
  output logic                     any_nonloop
);
  localparam int PW = $clog2(DEPTH);

  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    // walk oldest to youngest so the last match wins
    for (int k = 0; k < DEPTH; k++) begin
      logic [PW-1:0] idx;
      idx = rd_ptr + PW'(k);
      if (ent_vld[idx] && ent_addr[idx] == look_addr) begin
        hit      = 1'b1;
        hit_data = ent_data[idx];
      end
    end
  end

  always_comb begin
    any_nonloop = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (ent_vld[i] && lbl_pkg::is_nonloop(ent_lbl[i])) any_nonloop = 1'b1;
  end

endmodule

// File: rtl/lbl_order_unit.sv
module lbl_order_unit
  import lbl_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [1:0]    req_label,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [1:0]    mem_req_label,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata
);
  localparam int PW = $clog2(DEPTH);

  state_e        state;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata;
  logic [1:0]    op_lbl;
  logic          op_rmw;
  logic [DW-1:0] rsp_q;
  logic          busy_drain, busy_core, hold_drain;

  logic [AW-1:0]    ent_addr [DEPTH];
  logic [DW-1:0]    ent_data [DEPTH];
  logic [1:0]       ent_lbl  [DEPTH];
  logic [DEPTH-1:0] ent_vld;
  logic [PW-1:0]    rd_ptr;
  logic             q_empty, q_full, q_push, q_pop;
  logic             fwd_hit, any_nl;
  logic [DW-1:0]    fwd_data;
  logic             accept, core_wants, core_sel, drain_sel, mem_hs, mem_busy;

  sb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
    .clk, .rst_n,
    .push(q_push), .push_addr(req_addr), .push_data(req_wdata), .push_lbl(req_label),
    .pop(q_pop),
    .ent_addr, .ent_data, .ent_lbl, .ent_vld, .rd_ptr,
    .empty(q_empty), .full(q_full)
  );

  sb_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_lookup (
    .ent_addr, .ent_data, .ent_lbl, .ent_vld, .rd_ptr,
    .look_addr(req_addr),
    .hit(fwd_hit), .hit_data(fwd_data), .any_nonloop(any_nl)
  );

  // command admission by kind and label
  always_comb begin
    req_ready = 1'b0;
    if (state == ST_IDLE) begin
      case (req_op)
        OP_LOAD:  req_ready = !(is_nonloop(req_label) && any_nl);
        OP_STORE: req_ready = !q_full;
        default:  req_ready = q_empty;
      endcase
    end
  end

  assign accept = req_valid && req_ready;
  assign q_push = accept && (req_op == OP_STORE);

  // memory port arbitration: one transaction in flight, held requests keep the port
  assign mem_busy   = busy_drain || busy_core;
  assign core_wants = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign core_sel   = core_wants && !mem_busy && !hold_drain;
  assign drain_sel  = !core_sel && !mem_busy && !q_empty && (hold_drain || !core_wants);
  assign mem_hs     = mem_req_valid && mem_req_ready;
  assign q_pop      = mem_rsp_valid && busy_drain;

  assign mem_req_valid = core_sel || drain_sel;
  assign mem_req_write = drain_sel || (state == ST_WR_REQ);
  assign mem_req_addr  = drain_sel ? ent_addr[rd_ptr] : op_addr;
  assign mem_req_wdata = drain_sel ? ent_data[rd_ptr] : op_wdata;
  assign mem_req_label = drain_sel ? ent_lbl[rd_ptr]  : op_lbl;

  assign rsp_valid = (state == ST_RSP);
  assign rsp_rdata = rsp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      op_addr    <= '0;
      op_wdata   <= '0;
      op_lbl     <= '0;
      op_rmw     <= 1'b0;
      rsp_q      <= '0;
      busy_drain <= 1'b0;
      busy_core  <= 1'b0;
      hold_drain <= 1'b0;
    end else begin
      hold_drain <= drain_sel && !mem_req_ready;
      if (mem_rsp_valid) begin
        busy_drain <= 1'b0;
        busy_core  <= 1'b0;
      end
      if (mem_hs) begin
        if (drain_sel) busy_drain <= 1'b1;
        else           busy_core  <= 1'b1;
      end
      case (state)
        ST_IDLE: if (accept) begin
          op_addr  <= req_addr;
          op_wdata <= req_wdata;
          op_lbl   <= req_label;
          case (req_op)
            OP_LOAD: begin
              op_rmw <= 1'b0;
              if (fwd_hit) begin
                rsp_q <= fwd_data;
                state <= ST_RSP;
              end else begin
                state <= ST_RD_REQ;
              end
            end
            OP_RMW: begin
              op_rmw <= 1'b1;
              state  <= ST_RD_REQ;
            end
            default: ;
          endcase
        end
        ST_RD_REQ:  if (core_sel && mem_req_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid) begin
          rsp_q <= mem_rsp_rdata;
          state <= op_rmw ? ST_WR_REQ : ST_RSP;
        end
        ST_WR_REQ:  if (core_sel && mem_req_ready) state <= ST_WR_WAIT;
        ST_WR_WAIT: if (mem_rsp_valid) state <= ST_RSP;
        ST_RSP:     if (rsp_ready) state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assert_nonloop_read_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_sel && !mem_req_write && !op_rmw && is_nonloop(op_lbl)) |-> !any_nl);
  assert_rmw_on_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_sel && op_rmw) |-> q_empty);
  assert_rmw_write_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_WAIT && mem_rsp_valid && op_rmw) |=> (mem_req_valid -> mem_req_write));
  assert_single_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_drain && busy_core));
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && !req_ready));
  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata)));

endmodule

// File: tb/sim_lbl_order_unit.sv
module sim_lbl_order_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [1:0]  req_label = 2'd0;
  logic [7:0]  req_addr = 8'd0;
  logic [15:0] req_wdata = 16'd0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready;
  logic [1:0]  mem_req_label;
  logic [7:0]  mem_req_addr;
  logic [15:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [15:0] mem_rsp_rdata;

  int tests = 0, fails = 0;
  bit done = 0;

  lbl_order_unit #(.DEPTH(8), .AW(8), .DW(16)) u0 (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // program-order model and memory-port monitor state
  logic [15:0] shadow [16];
  logic [7:0]  exp_a [1024];
  logic [15:0] exp_d [1024];
  logic [1:0]  exp_l [1024];
  int wr_sent = 0, wr_seen = 0, nl_sent = 0, nl_written = 0, rd_seen = 0, wr_at_rd = 0;
  bit cur_ld_nl = 0, cur_rmw = 0, rmw_wr_pending = 0;
  logic [7:0] rmw_addr;
  bit mem_hold = 0;
  int mem_lat = 1;

  logic [15:0] mem [16];
  logic [15:0] lfsr, rd_q;
  logic        pend, prev_stall, prev_wr;
  logic [7:0]  prev_addr;
  int          ack_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_rdata <= '0;
      pend <= 1'b0;
      prev_stall <= 1'b0;
      lfsr <= 16'hACE1;
      for (int i = 0; i < 16; i++) mem[i] <= 16'h100 + 16'(i);
    end else begin
      mem_rsp_valid <= 1'b0;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_req_ready <= !mem_hold && (lfsr[0] || lfsr[3]);
      if (prev_stall)
        chk(mem_req_valid && mem_req_addr == prev_addr && mem_req_write == prev_wr,
            "R9 request held", int'(mem_req_addr), int'(prev_addr));
      prev_stall <= mem_req_valid && !mem_req_ready;
      prev_addr  <= mem_req_addr;
      prev_wr    <= mem_req_write;
      if (pend) begin
        if (ack_cnt == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= rd_q;
          pend <= 1'b0;
        end else ack_cnt <= ack_cnt - 1;
      end
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          if (rmw_wr_pending) begin
            chk(mem_req_addr == rmw_addr, "R6 swap write address", int'(mem_req_addr), int'(rmw_addr));
            rmw_wr_pending = 0;
          end else begin
            chk(mem_req_addr == exp_a[wr_seen] && mem_req_wdata == exp_d[wr_seen]
                && mem_req_label == exp_l[wr_seen],
                "R2 drain order", int'(mem_req_wdata), int'(exp_d[wr_seen]));
            if (exp_l[wr_seen][1]) nl_written++;
            wr_seen++;
          end
          mem[mem_req_addr[3:0]] <= mem_req_wdata;
        end else begin
          chk(!rmw_wr_pending, "R6 nothing between swap halves", 1, 0);
          rd_seen++;
          wr_at_rd = wr_seen;
          if (cur_ld_nl) chk(nl_written == nl_sent, "R3 non-loop read order", nl_written, nl_sent);
          if (cur_rmw) begin
            chk(wr_seen == wr_sent, "R6 buffer drained before swap", wr_seen, wr_sent);
            rmw_wr_pending = 1;
            rmw_addr = mem_req_addr;
          end
          rd_q <= mem[mem_req_addr[3:0]];
        end
        pend <= 1'b1;
        ack_cnt <= mem_lat;
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [1:0] lbl, input logic [7:0] a,
                       input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_label = lbl; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (op == 2'd1) begin
      exp_a[wr_sent] = a; exp_d[wr_sent] = d; exp_l[wr_sent] = lbl;
      wr_sent++;
      if (lbl[1]) nl_sent++;
      shadow[a[3:0]] = d;
    end
  endtask

  task automatic probe(input logic [1:0] op, input logic [1:0] lbl, input logic [7:0] a,
                       input bit exp_rdy, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_label = lbl; req_addr = a; req_wdata = 16'hDEAD;
    #1;
    chk(req_ready == exp_rdy, tag, int'(req_ready), int'(exp_rdy));
    req_valid = 1'b0;
  endtask

  task automatic get_rsp(input logic [15:0] expv, input int hold, input string tag);
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    chk(rsp_rdata == expv, tag, int'(rsp_rdata), int'(expv));
    if (hold > 0) begin
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk(rsp_valid && rsp_rdata == expv && !req_ready, "R8 result held", int'(rsp_rdata), int'(expv));
      end
      rsp_ready = 1'b1;
    end
    @(posedge clk); #1;
    chk(!rsp_valid, "R8 result released", int'(rsp_valid), 0);
  endtask

  task automatic do_load(input logic [1:0] lbl, input logic [7:0] a, input int hold, input string tag);
    logic [15:0] expv;
    expv = shadow[a[3:0]];
    cur_ld_nl = lbl[1];
    if (hold > 0) rsp_ready = 1'b0;
    issue(2'd0, lbl, a, 16'h0);
    get_rsp(expv, hold, tag);
    cur_ld_nl = 0;
  endtask

  task automatic do_rmw(input logic [7:0] a, input logic [15:0] d);
    logic [15:0] expv;
    expv = shadow[a[3:0]];
    cur_rmw = 1;
    issue(2'd2, 2'd2, a, d);
    shadow[a[3:0]] = d;
    get_rsp(expv, 0, "R6 swap old value");
    cur_rmw = 0;
  endtask

  task automatic do_fence();
    issue(2'd3, 2'd0, 8'd0, 16'd0);
    chk(wr_seen == wr_sent, "R7 fence after drain", wr_seen, wr_sent);
    @(negedge clk);
    chk(!rsp_valid, "R7 fence gives no response", int'(rsp_valid), 0);
  endtask

  initial begin
    int base, rd0;
    for (int i = 0; i < 16; i++) shadow[i] = 16'h100 + 16'(i);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!rsp_valid && !mem_req_valid, "R1 idle outputs", int'(rsp_valid), 0);
    chk(req_ready, "R1 ready on empty buffer", int'(req_ready), 1);

    // R2 full buffer, R5 forwarding while memory stalls
    mem_hold = 1; repeat (3) @(posedge clk);
    for (int i = 0; i < 8; i++) issue(2'd1, 2'd0, 8'(i), 16'h2000 + 16'(i));
    probe(2'd1, 2'd0, 8'd9, 1'b0, "R2 store stalled when full");
    rd0 = rd_seen;
    do_load(2'd0, 8'd3, 0, "R5 forward from buffer");
    chk(rd_seen == rd0, "R5 no memory read on hit", rd_seen, rd0);
    mem_hold = 0;
    do_fence();

    // R5 youngest of two matches
    mem_hold = 1; repeat (3) @(posedge clk);
    issue(2'd1, 2'd0, 8'd7, 16'h0A01);
    issue(2'd1, 2'd1, 8'd7, 16'h0A02);
    do_load(2'd0, 8'd7, 0, "R5 youngest match");
    // R3, R4, R6, R7, R10 admission with a non-loop store buffered
    issue(2'd1, 2'd2, 8'd5, 16'h0B05);
    probe(2'd0, 2'd2, 8'd6, 1'b0, "R3 non-loop load stalls");
    probe(2'd0, 2'd3, 8'd6, 1'b0, "R10 label 3 acts as non-loop");
    probe(2'd0, 2'd1, 8'd6, 1'b1, "R4 loop load admitted");
    probe(2'd0, 2'd0, 8'd6, 1'b1, "R4 non-competing load admitted");
    probe(2'd2, 2'd0, 8'd6, 1'b0, "R6 swap waits for empty");
    probe(2'd3, 2'd0, 8'd6, 1'b0, "R7 fence waits for empty");
    mem_hold = 0;
    do_load(2'd2, 8'd6, 0, "R3 non-loop load value");

    // R4 bypass at the memory port
    mem_lat = 6;
    base = wr_seen;
    issue(2'd1, 2'd1, 8'd1, 16'h0C01);
    issue(2'd1, 2'd1, 8'd2, 16'h0C02);
    issue(2'd1, 2'd1, 8'd3, 16'h0C03);
    do_load(2'd1, 8'd9, 0, "R4 loop load value");
    chk(wr_at_rd < base + 3, "R4 read ahead of stores", wr_at_rd, base + 2);
    mem_lat = 1;

    // R8 result held under back-pressure
    do_load(2'd0, 8'd2, 3, "R8 held load value");
    do_load(2'd2, 8'd12, 2, "R8 held memory read");

    // R6 swap
    issue(2'd1, 2'd0, 8'd4, 16'h0D04);
    do_rmw(8'd4, 16'h0E04);
    do_load(2'd2, 8'd4, 0, "R6 swap stored new value");

    // sweep: store label x load label x same/different address
    for (int sl = 0; sl < 4; sl++)
      for (int ll = 0; ll < 4; ll++)
        for (int same = 0; same < 2; same++) begin
          mem_lat = (sl + ll) % 3;
          issue(2'd1, 2'(sl), 8'd10, 16'(sl * 64 + ll * 8 + same));
          issue(2'd1, 2'(sl), 8'd11, 16'(16'h4000 + sl * 16 + ll));
          do_load(2'(ll), same ? 8'd10 : 8'd12, 0, "R3 R4 R5 sweep value");
        end

    // random mix
    for (int n = 0; n < 400; n++) begin
      int k;
      logic [7:0] a;
      logic [1:0] l;
      k = $urandom_range(0, 9);
      a = 8'($urandom_range(0, 15));
      l = 2'($urandom_range(0, 3));
      mem_lat = $urandom_range(0, 3);
      if (k < 5)      issue(2'd1, l, a, 16'($urandom));
      else if (k < 8) do_load(l, a, 0, "R5 R3 random load value");
      else if (k < 9) do_rmw(a, 16'($urandom));
      else            do_fence();
    end
    do_fence();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule